// File: doc/BRIEF.md
# Processor Packet Endpoint

This block lets a processor exchange 16-bit-word packets with a link through seven 16-bit registers. To send, software writes the packet into a transmit buffer one word at a time and then sets a launch bit. The buffered words then go out on a word stream that carries start and end markers and a ready handshake. While the words go out, the endpoint puts its own running counter into the header's block-counter byte.

Received packets are stored whole in a receive buffer, or they are discarded. Software pops them one word at a time. The status register shows whether the word the next read returns is the first or last of its packet. Header checks raise sticky error flags: a payload length that does not match, and a block counter that does not increase. Software clears these flags by writing the value it read back into the status register. An interrupt register combines buffer and packet events with enable masks to drive one interrupt line.

A packet header is four words: target address, source address, a word with the packet type in bits 7:0 and the block counter in bits 15:8, then the payload length in bytes. The payload takes (length+1)/2 words after the header.

Top module: `pep_endpoint`

## Requirements
- R1: After reset the status register (address 3) reads 0x0000, the control register (address 1) reads 0x0000, the interrupt register (address 6) reads 0x0020 and `irq` is low.
- R2: Each write to address 0 appends a word to the transmit buffer. Writing address 1 with bit 15 set sends all buffered words in write order as one packet: `txSop` on the first word, `txEop` on the last, each word held while `txReady` is low. A launch with an empty buffer sends nothing.
- R3: On transmit, bits 15:8 of packet word 2 are replaced with an 8-bit counter. The counter starts at 0 after reset and advances by one for each packet sent. All other words pass unchanged.
- R4: Status bit 0 is set while the transmit buffer holds words and no packet is being sent. Bit 1 is set while a packet is being sent. Bit 2 is set while the transmit buffer is full.
- R5: A write to address 0 while a packet is being sent, or while the buffer is full, is discarded and sets status bit 3.
- R6: A read of address 2 returns the oldest stored receive word and removes it. Status bit 15 shows that a word is stored, bit 13 that it is the first word of its packet, bit 12 that it is the last. A read of address 2 with no word stored returns 0 and changes nothing.
- R7: A packet is discarded and status bit 11 is set when it arrives while control bit 12 is clear, or when the receive buffer cannot hold all of it. A discarded packet leaves no stored words.
- R8: Control bit 12 (receive enable) is stored and reads back. Control bit 15 reads as 0.
- R9: Interrupt register bit 5 is transmit idle and empty. Bit 6 is a packet-sent flag. Bit 7 is a packet-stored flag. Bit 8 is receive data present. Bits 15:12 enable bits 5 to 8 in order. `irq` is the OR of the enabled bits. Writing 1 to bit 6 or bit 7 clears it.
- R10: A stored packet whose word count differs from 4 plus (length+1)/2 sets status bit 8.
- R11: A stored packet whose block counter is not greater than that of the previous stored packet sets status bit 9.
- R12: A stored packet whose end word arrives with `rxFcsErr` high sets status bit 10.
- R13: Status bits 3 and 8 to 11 stay set until a 1 is written to them at address 3. Status bits 4 to 7 and 14 read 0.
- R14: Addresses 4 and 5 are read/write 16-bit address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of address 2 removes a word) |
| regAddr | input | 3 | Register index |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt |
| txValid | output | 1 | Outgoing word valid |
| txReady | input | 1 | Link accepts outgoing word |
| txData | output | 16 | Outgoing word |
| txSop | output | 1 | First word of outgoing packet |
| txEop | output | 1 | Last word of outgoing packet |
| rxValid | input | 1 | Incoming word valid |
| rxData | input | 16 | Incoming word |
| rxSop | input | 1 | First word of incoming packet |
| rxEop | input | 1 | Last word of incoming packet |
| rxFcsErr | input | 1 | Frame check failed, sampled with rxEop |

## Verification
Transmit runs over a table of packet lengths from 2 to 8 words with different contents. The table shows whether the block-counter byte is replaced only in word 2, and whether the counter steps once per packet even when a packet is too short to carry it. Receive packets are sent in four forms: well-formed, short against the length field, with a repeated block counter, and flagged with a bad frame check. Each form should set exactly one status bit. Disabled reception and a packet larger than the buffer exercise the discard path, and a clean packet sent afterwards shows that no partial words were left behind.

// File: rtl/pep_pkg.sv
package pep_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_TX_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TX_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RX_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DEV     = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_TGT     = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_IRQ     = 3'd6;

  // status bit positions
  localparam int ST_BUILD    = 0;
  localparam int ST_SENDING  = 1;
  localparam int ST_TX_FULL  = 2;
  localparam int ST_TX_ERR   = 3;
  localparam int ST_LEN_ERR  = 8;
  localparam int ST_FRM_ERR  = 9;
  localparam int ST_FCS_ERR  = 10;
  localparam int ST_DROP     = 11;
  localparam int ST_LAST     = 12;
  localparam int ST_FIRST    = 13;
  localparam int ST_AVAIL    = 15;

  // control bit positions
  localparam int CTRL_RX_EN  = 12;
  localparam int CTRL_LAUNCH = 15;

  // interrupt register bit positions
  localparam int IRQ_TX_FREE  = 5;
  localparam int IRQ_TX_DONE  = 6;
  localparam int IRQ_RX_PKT   = 7;
  localparam int IRQ_RX_AVAIL = 8;
  localparam int IRQ_MASK_LSB = 12;

  // header layout
  localparam int HDR_WORDS    = 4;
  localparam int HDR_BC_WORD  = 2;
  localparam int HDR_LEN_WORD = 3;

  typedef struct packed {
    logic              txPush;
    logic              txLaunch;
    logic              rxPop;
    logic              rxEnable;
    logic [DATA_W-1:0] wrData;
  } pep_strobe_t;

  typedef struct packed {
    logic              txBusy;
    logic              txFull;
    logic              txEmpty;
    logic              txDoneEv;
    logic              rxAvail;
    logic              rxFirst;
    logic              rxLast;
    logic [DATA_W-1:0] rxHead;
    logic              rxPktEv;
    logic              rxDropEv;
    logic              rxLenErrEv;
    logic              rxFrameErrEv;
    logic              rxFcsErrEv;
  } pep_event_t;
endpackage

// File: rtl/pep_fifo.sv
// Word FIFO with a speculative write pointer. Words become visible to the
// reader only on commit; rewind discards uncommitted words. DEPTH must be a
// power of two.
module pep_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     push,
  input  logic [WIDTH-1:0]         pushData,
  input  logic                     commit,
  input  logic                     rewind,
  input  logic                     pop,
  output logic [WIDTH-1:0]         headData,
  output logic                     specFull,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, commitPtr, rdPtr, basePtr, nextPtr;
  logic doPop;

  assign basePtr  = rewind ? commitPtr : wrPtr;
  assign nextPtr  = basePtr + {{AW{1'b0}}, push};
  assign count    = commitPtr - rdPtr;
  assign doPop    = pop && (commitPtr != rdPtr);
  assign specFull = (wrPtr - rdPtr) == (AW+1)'(DEPTH);
  assign headData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[basePtr[AW-1:0]] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
    end else begin
      wrPtr <= nextPtr;
      if (commit) commitPtr <= nextPtr;
      if (doPop)  rdPtr     <= rdPtr + {{AW{1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/pep_datapath.sv
module pep_datapath
  import pep_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pep_strobe_t       stb,
  output pep_event_t        evt,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  output logic              txSop,
  output logic              txEop,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              rxFcsErr
);
  localparam int TXCW = $clog2(TX_DEPTH) + 1;
  localparam int RXCW = $clog2(RX_DEPTH) + 1;
  localparam int RXW  = DATA_W + 2;   // {first, last, data}
  localparam int CNTW = DATA_W + 1;

  // ---------------- transmit ----------------
  logic [DATA_W-1:0] txHead;
  logic              txFull, txBusy, txFire, txLastFire, txStart;
  logic [TXCW-1:0]   txCount, txIdx, txLeft;
  logic [7:0]        blockCtr;

  pep_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pushData(stb.wrData),
    .commit(1'b1), .rewind(1'b0), .pop(txFire),
    .headData(txHead), .specFull(txFull), .count(txCount)
  );

  assign txStart    = stb.txLaunch && !txBusy && (txCount != '0);
  assign txFire     = txBusy && txReady;
  assign txLastFire = txFire && (txLeft == TXCW'(1));

  assign txValid = txBusy;
  assign txSop   = txBusy && (txIdx == '0);
  assign txEop   = txBusy && (txLeft == TXCW'(1));
  assign txData  = (txIdx == TXCW'(HDR_BC_WORD)) ? {blockCtr, txHead[7:0]} : txHead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      txIdx    <= '0;
      txLeft   <= '0;
      blockCtr <= '0;
    end else if (txStart) begin
      txBusy <= 1'b1;
      txIdx  <= '0;
      txLeft <= txCount;
    end else if (txFire) begin
      txIdx  <= txIdx + TXCW'(1);
      txLeft <= txLeft - TXCW'(1);
      if (txLastFire) begin
        txBusy   <= 1'b0;
        blockCtr <= blockCtr + 8'd1;
      end
    end
  end

  // ---------------- receive ----------------
  logic [RXW-1:0]    rxHeadW;
  logic              rxSpecFull;
  logic [RXCW-1:0]   rxCount;
  logic              inPkt, dropping, haveBc;
  logic [DATA_W-1:0] wordCnt, hdrLen, idx, lenNow;
  logic [7:0]        hdrBc, prevBc, bcNow;
  logic              startNow, active, baseDrop, overflow, rxPush;
  logic              abandon, eopNow, rxCommit, rxRewind, hasBc;
  logic [CNTW-1:0]   total, expWords;

  assign startNow = rxValid && rxSop;
  assign active   = rxValid && (rxSop || inPkt);
  assign idx      = startNow ? '0 : wordCnt;
  assign baseDrop = startNow ? !stb.rxEnable : dropping;
  assign overflow = active && !baseDrop && rxSpecFull;
  assign rxPush   = active && !baseDrop && !rxSpecFull;
  assign abandon  = startNow && inPkt && !dropping;
  assign eopNow   = active && rxEop;
  assign rxCommit = eopNow && rxPush;
  assign rxRewind = abandon || overflow;

  assign total    = {1'b0, idx} + CNTW'(1);
  assign lenNow   = (idx == DATA_W'(HDR_LEN_WORD)) ? rxData : hdrLen;
  assign expWords = CNTW'(HDR_WORDS) + (({1'b0, lenNow} + CNTW'(1)) >> 1);
  assign bcNow    = (idx == DATA_W'(HDR_BC_WORD)) ? rxData[15:8] : hdrBc;
  assign hasBc    = total > CNTW'(HDR_BC_WORD);

  pep_fifo #(.WIDTH(RXW), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData({rxSop, rxEop, rxData}),
    .commit(rxCommit), .rewind(rxRewind), .pop(stb.rxPop),
    .headData(rxHeadW), .specFull(rxSpecFull), .count(rxCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt    <= 1'b0;
      dropping <= 1'b0;
      wordCnt  <= '0;
      hdrLen   <= '0;
      hdrBc    <= '0;
      prevBc   <= '0;
      haveBc   <= 1'b0;
    end else begin
      if (active) begin
        inPkt    <= !rxEop;
        dropping <= (baseDrop || overflow) && !rxEop;
        wordCnt  <= idx + DATA_W'(1);
        if (idx == DATA_W'(HDR_LEN_WORD)) hdrLen <= rxData;
        if (idx == DATA_W'(HDR_BC_WORD))  hdrBc  <= rxData[15:8];
      end
      if (rxCommit && hasBc) begin
        prevBc <= bcNow;
        haveBc <= 1'b1;
      end
    end
  end

  always_comb begin
    evt              = '0;
    evt.txBusy       = txBusy;
    evt.txFull       = txFull;
    evt.txEmpty      = (txCount == '0);
    evt.txDoneEv     = txLastFire;
    evt.rxAvail      = (rxCount != '0);
    evt.rxFirst      = evt.rxAvail && rxHeadW[RXW-1];
    evt.rxLast       = evt.rxAvail && rxHeadW[RXW-2];
    evt.rxHead       = rxHeadW[DATA_W-1:0];
    evt.rxPktEv      = rxCommit;
    evt.rxDropEv     = abandon || (eopNow && !rxPush);
    evt.rxLenErrEv   = rxCommit && ((total < CNTW'(HDR_WORDS)) || (total != expWords));
    evt.rxFrameErrEv = rxCommit && hasBc && haveBc && (bcNow <= prevBc);
    evt.rxFcsErrEv   = rxCommit && rxFcsErr;
  end
endmodule

// File: rtl/pep_ctrl.sv
module pep_ctrl
  import pep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output pep_strobe_t       stb,
  input  pep_event_t        evt,
  output logic [4:0]        errFlags
);
  logic rxEnable, errTx, errLen, errFrame, errFcs, errDrop, txDoneFlag, rxPktFlag;
  logic [DATA_W-1:0] devAddr, tgtAddr, clrSt, clrIrq, statusWord, irqWord, ctrlWord;
  logic [3:0] irqMask, irqPend;
  logic wrTx, wrCtrl, wrStatus, wrIrq, txBlocked;

  assign wrTx      = regWrEn && (regAddr == ADDR_TX_DATA);
  assign wrCtrl    = regWrEn && (regAddr == ADDR_TX_CTRL);
  assign wrStatus  = regWrEn && (regAddr == ADDR_STATUS);
  assign wrIrq     = regWrEn && (regAddr == ADDR_IRQ);
  assign txBlocked = evt.txBusy || evt.txFull;
  assign clrSt     = wrStatus ? regWrData : '0;
  assign clrIrq    = wrIrq ? regWrData : '0;

  always_comb begin
    stb          = '0;
    stb.txPush   = wrTx && !txBlocked;
    stb.txLaunch = wrCtrl && regWrData[CTRL_LAUNCH];
    stb.rxPop    = regRdEn && (regAddr == ADDR_RX_DATA) && evt.rxAvail;
    stb.rxEnable = rxEnable;
    stb.wrData   = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable   <= 1'b0;
      devAddr    <= '0;
      tgtAddr    <= '0;
      irqMask    <= '0;
      errTx      <= 1'b0;
      errLen     <= 1'b0;
      errFrame   <= 1'b0;
      errFcs     <= 1'b0;
      errDrop    <= 1'b0;
      txDoneFlag <= 1'b0;
      rxPktFlag  <= 1'b0;
    end else begin
      if (wrCtrl) rxEnable <= regWrData[CTRL_RX_EN];
      if (regWrEn && regAddr == ADDR_DEV) devAddr <= regWrData;
      if (regWrEn && regAddr == ADDR_TGT) tgtAddr <= regWrData;
      if (wrIrq) irqMask <= regWrData[IRQ_MASK_LSB +: 4];
      // sticky flags: a new event wins over a clear in the same cycle
      errTx      <= (errTx      && !clrSt[ST_TX_ERR])   || (wrTx && txBlocked);
      errLen     <= (errLen     && !clrSt[ST_LEN_ERR])  || evt.rxLenErrEv;
      errFrame   <= (errFrame   && !clrSt[ST_FRM_ERR])  || evt.rxFrameErrEv;
      errFcs     <= (errFcs     && !clrSt[ST_FCS_ERR])  || evt.rxFcsErrEv;
      errDrop    <= (errDrop    && !clrSt[ST_DROP])     || evt.rxDropEv;
      txDoneFlag <= (txDoneFlag && !clrIrq[IRQ_TX_DONE]) || evt.txDoneEv;
      rxPktFlag  <= (rxPktFlag  && !clrIrq[IRQ_RX_PKT])  || evt.rxPktEv;
    end
  end

  assign errFlags = {errDrop, errFcs, errFrame, errLen, errTx};
  assign irqPend  = {evt.rxAvail, rxPktFlag, txDoneFlag, evt.txEmpty && !evt.txBusy};
  assign irq      = |(irqPend & irqMask);

  always_comb begin
    statusWord              = '0;
    statusWord[ST_BUILD]    = !evt.txEmpty && !evt.txBusy;
    statusWord[ST_SENDING]  = evt.txBusy;
    statusWord[ST_TX_FULL]  = evt.txFull;
    statusWord[ST_TX_ERR]   = errTx;
    statusWord[ST_LEN_ERR]  = errLen;
    statusWord[ST_FRM_ERR]  = errFrame;
    statusWord[ST_FCS_ERR]  = errFcs;
    statusWord[ST_DROP]     = errDrop;
    statusWord[ST_LAST]     = evt.rxLast;
    statusWord[ST_FIRST]    = evt.rxFirst;
    statusWord[ST_AVAIL]    = evt.rxAvail;

    irqWord                 = '0;
    irqWord[IRQ_TX_FREE +: 4]  = irqPend;
    irqWord[IRQ_MASK_LSB +: 4] = irqMask;

    ctrlWord                = '0;
    ctrlWord[CTRL_RX_EN]    = rxEnable;
  end

  always_comb begin
    case (regAddr)
      ADDR_TX_CTRL: regRdData = ctrlWord;
      ADDR_RX_DATA: regRdData = evt.rxAvail ? evt.rxHead : '0;
      ADDR_STATUS:  regRdData = statusWord;
      ADDR_DEV:     regRdData = devAddr;
      ADDR_TGT:     regRdData = tgtAddr;
      ADDR_IRQ:     regRdData = irqWord;
      default:      regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pep_endpoint.sv
module pep_endpoint
  import pep_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  output logic              txSop,
  output logic              txEop,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              rxFcsErr
);
  pep_strobe_t stb;
  pep_event_t  evt;
  logic [4:0]  errFlags;

  pep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .stb(stb), .evt(evt), .errFlags(errFlags)
  );

  pep_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .evt(evt),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txSop(txSop), .txEop(txEop),
    .rxValid(rxValid), .rxData(rxData), .rxSop(rxSop), .rxEop(rxEop), .rxFcsErr(rxFcsErr)
  );
endmodule

// File: rtl/pep_endpoint_checker.sv
module pep_endpoint_checker
  import pep_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] txData,
  input logic              txSop,
  input logic              txEop,
  input logic              rxAvail,
  input logic [4:0]        errFlags
);
  assert_sop_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    txSop |-> txValid);

  assert_gap_after_eop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txEop) |=> !txValid);

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txSop) && $stable(txEop)));

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_RX_DATA && !rxAvail) |-> (regRdData == '0));

  assert_sticky_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_STATUS) |=> ((errFlags & $past(errFlags)) == $past(errFlags)));
endmodule

bind pep_endpoint pep_endpoint_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regRdData(regRdData), .txValid(txValid), .txReady(txReady), .txData(txData),
  .txSop(txSop), .txEop(txEop), .rxAvail(evt.rxAvail), .errFlags(errFlags)
);

// File: tb/pep_endpoint_bench.sv
`timescale 1ns/1ps
module pep_endpoint_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic irq, txValid, txSop, txEop;
  logic txReady = 1'b1;
  logic [15:0] txData;
  logic rxValid = 1'b0, rxSop = 1'b0, rxEop = 1'b0, rxFcsErr = 1'b0;
  logic [15:0] rxData = '0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [15:0] capData [0:127];
  logic        capSop  [0:127];
  logic        capEop  [0:127];
  int capN = 0;
  logic [15:0] pkt [0:31];

  localparam int VEC_N = 4;
  localparam int VEC_LEN [VEC_N] = '{4, 5, 2, 8};
  localparam logic [15:0] VEC_SEED [VEC_N] = '{16'h1000, 16'h2A00, 16'hA5A0, 16'h3C10};

  always #4 clk = ~clk;   // 125 MHz

  pep_endpoint u_pep_endpoint (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txSop(txSop), .txEop(txEop),
    .rxValid(rxValid), .rxData(rxData), .rxSop(rxSop), .rxEop(rxEop), .rxFcsErr(rxFcsErr)
  );

  // link-side collector: values are stable from just after a falling edge
  always @(negedge clk) begin
    #1;
    if (rstN && txValid && txReady && capN < 128) begin
      capData[capN] = txData;
      capSop[capN]  = txSop;
      capEop[capN]  = txEop;
      capN = capN + 1;
    end
  end

  task automatic checkEq(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic sendRx(input int n, input logic fcs);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = pkt[k];
      rxSop = (k == 0); rxEop = (k == n - 1);
      rxFcsErr = (k == n - 1) && fcs;
    end
    @(negedge clk);
    rxValid = 1'b0; rxSop = 1'b0; rxEop = 1'b0; rxFcsErr = 1'b0;
  endtask

  task automatic drain(input int n);
    logic [15:0] d;
    for (int k = 0; k < n; k++) busRead(3'd2, d);
  endtask

  task automatic setHeader(input logic [7:0] bc, input logic [15:0] len);
    pkt[0] = 16'h0011; pkt[1] = 16'h0022; pkt[2] = {bc, 8'h07}; pkt[3] = len;
    for (int k = 4; k < 32; k++) pkt[k] = 16'hC000 + 16'(k);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    int base;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // reset state
    busRead(3'd3, d); checkEq("R1 status", d, 16'h0000);
    busRead(3'd1, d); checkEq("R1 control", d, 16'h0000);
    busRead(3'd6, d); checkEq("R1 irq reg", d, 16'h0020);
    checkEq("R1 irq pin", {15'd0, irq}, 16'h0000);

    // transmit vector table
    for (int e = 0; e < VEC_N; e++) begin
      base = capN;
      for (int k = 0; k < VEC_LEN[e]; k++)
        busWrite(3'd0, 16'(VEC_SEED[e] + 16'(k) * 16'h0111));
      busRead(3'd3, d); checkEq("R4 building", d, 16'h0001);
      busWrite(3'd1, 16'h8000);
      repeat (VEC_LEN[e] + 4) @(negedge clk);
      checkEq("R2 word count", 16'(capN - base), 16'(VEC_LEN[e]));
      for (int k = 0; k < VEC_LEN[e]; k++) begin
        logic [15:0] w;
        w = 16'(VEC_SEED[e] + 16'(k) * 16'h0111);
        if (k == 2) w = {8'(e), w[7:0]};
        checkEq("R3 word", capData[base + k], w);
        checkEq("R2 markers", {14'd0, capSop[base + k], capEop[base + k]},
                {14'd0, k == 0, k == VEC_LEN[e] - 1});
      end
      busRead(3'd6, d); checkEq("R9 sent flag", d & 16'h0040, 16'h0040);
      busWrite(3'd6, 16'h0040);
    end

    // writes while sending are discarded
    txReady = 1'b0;
    for (int k = 0; k < 4; k++) busWrite(3'd0, 16'h4000 + 16'(k) * 16'h0111);
    busWrite(3'd1, 16'h8000);
    busWrite(3'd0, 16'h7777);
    busRead(3'd3, d); checkEq("R5 busy write error", d, 16'h000A);
    busWrite(3'd3, 16'h0008);
    busRead(3'd3, d); checkEq("R13 clear tx error", d, 16'h0002);
    base = capN;
    @(negedge clk); txReady = 1'b1;
    repeat (8) @(negedge clk);
    checkEq("R5 count unchanged", 16'(capN - base), 16'd4);
    checkEq("R3 counter 4", capData[base + 2], 16'h0422);
    checkEq("R5 last word kept", capData[base + 3], 16'h4333);

    // full buffer
    for (int k = 0; k < 16; k++) busWrite(3'd0, 16'h5000 + 16'(k));
    busRead(3'd3, d); checkEq("R4 full", d, 16'h0005);
    busWrite(3'd0, 16'hDEAD);
    busRead(3'd3, d); checkEq("R5 full write error", d, 16'h000D);
    busWrite(3'd3, 16'h000D);
    base = capN;
    busWrite(3'd1, 16'h8000);
    repeat (22) @(negedge clk);
    checkEq("R2 full packet", 16'(capN - base), 16'd16);
    checkEq("R5 no extra word", capData[base + 15], 16'h500F);

    // receive while disabled
    setHeader(8'h01, 16'd3);
    sendRx(6, 1'b0);
    busRead(3'd3, d); checkEq("R7 disabled drop", d, 16'h0800);
    busRead(3'd2, d); checkEq("R6 empty read", d, 16'h0000);
    busRead(3'd3, d); checkEq("R6 empty read no change", d, 16'h0800);
    busWrite(3'd3, d);
    busRead(3'd3, d); checkEq("R13 clear drop", d, 16'h0000);

    // launch with empty buffer, enable reception
    base = capN;
    busWrite(3'd1, 16'h9000);
    repeat (5) @(negedge clk);
    checkEq("R2 empty launch", 16'(capN - base), 16'd0);
    busRead(3'd1, d); checkEq("R8 control readback", d, 16'h1000);
    busWrite(3'd6, 16'h80C0);
    busRead(3'd6, d); checkEq("R9 mask and clear", d, 16'h8020);
    checkEq("R9 irq idle", {15'd0, irq}, 16'h0000);

    // clean packet
    setHeader(8'h01, 16'd3);
    sendRx(6, 1'b0);
    checkEq("R9 irq data", {15'd0, irq}, 16'h0001);
    busRead(3'd6, d); checkEq("R9 irq reg data", d, 16'h81A0);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] s;
      busRead(3'd3, s);
      checkEq("R6 first/last", s, 16'h8000 | (k == 0 ? 16'h2000 : 16'h0) | (k == 5 ? 16'h1000 : 16'h0));
      busRead(3'd2, d); checkEq("R6 data", d, pkt[k]);
    end
    busRead(3'd3, d); checkEq("R6 drained", d, 16'h0000);
    checkEq("R9 irq drained", {15'd0, irq}, 16'h0000);

    // length mismatch
    setHeader(8'h02, 16'd4);
    sendRx(5, 1'b0);
    busRead(3'd3, d); checkEq("R10 length error", d, 16'hA100);
    drain(5); busWrite(3'd3, 16'h0100);

    // repeated block counter
    setHeader(8'h02, 16'd0);
    sendRx(4, 1'b0);
    busRead(3'd3, d); checkEq("R11 frame counter", d, 16'hA200);
    drain(4); busWrite(3'd3, 16'h0200);

    // bad frame check
    setHeader(8'h03, 16'd1);
    sendRx(5, 1'b1);
    busRead(3'd3, d); checkEq("R12 fcs error", d, 16'hA400);
    drain(5); busWrite(3'd3, 16'h0400);

    // oversized packet
    setHeader(8'h04, 16'd32);
    sendRx(20, 1'b0);
    busRead(3'd3, d); checkEq("R7 overflow drop", d, 16'h0800);
    busWrite(3'd3, 16'h0800);
    setHeader(8'h09, 16'd0);
    sendRx(4, 1'b0);
    busRead(3'd3, d); checkEq("R7 clean after drop", d, 16'hA000);
    busRead(3'd2, d); checkEq("R7 no leftover words", d, 16'h0011);
    drain(3);

    // address registers
    busWrite(3'd4, 16'h1234);
    busWrite(3'd5, 16'hBEEF);
    busRead(3'd4, d); checkEq("R14 device address", d, 16'h1234);
    busRead(3'd5, d); checkEq("R14 target address", d, 16'hBEEF);

    summary();
  end
endmodule